// File: doc/BRIEF.md
# Planar Adaptive Mesh Route Selector

This block makes the routing decision for one hop of a packet in a three-dimensional mesh router. From the coordinates of the current node and the destination, the routing phase the head flit carries, and a per-output flag saying that port cannot take the packet now, it picks an output port and a virtual-channel class. It also returns the phase value that the head flit carries on to the next hop.

Routing is adaptive inside two planes that are always taken in the same sequence: first the X-Y plane, then the Y-Z plane. The packet stays in the X-Y plane until its X offset is zero, and it never goes back to a plane it has left. When every productive port of the active plane is blocked, the packet drops for good into an escape class that routes in strict X, then Y, then Z order and ignores the blocked flags. The decision logic is combinational, and its result is captured in a single register stage.

Top module: `pa_route_sel`

## Requirements
- R1: The outputs are registered. `out_valid` is low during reset and in the first cycle after it, and each cycle with `in_valid` high gives `out_valid` high with its result on the following clock edge.
- R2: When all three coordinates equal the destination, the port is the local ejection port (code 0). The phase is returned unchanged, except that the unused code 3 comes back as 2. The escape class bit is 1 exactly when that phase is escape.
- R3: In phase 0 (X-Y plane) with the X offset non-zero, only the productive X and Y ports are candidates, and the returned phase stays 0.
- R4: When more than one productive port of the active plane is free, the one in the lowest dimension is taken (X before Y before Z).
- R5: A packet in phase 0 whose X offset is zero moves to phase 1 (Y-Z plane) and chooses between the productive Y and Z ports. A packet presented in phase 1 never comes back with phase 0.
- R6: When every productive port of the active plane is blocked, the result is phase 2 (escape), escape class bit 1, and the dimension-order port. A port returned with escape class 0 is never one whose blocked flag was set.
- R7: In phase 2 (and the unused phase 3), routing is dimension order (the first non-zero offset of X, Y, Z), the blocked flags are ignored, and the phase out is 2 with escape class 1.
- R8: A packet presented in phase 1 with a non-zero X offset is sent to the escape class with dimension-order routing.
- R9: Port codes: 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-, 5 Z+, 6 Z-. Plus means the destination coordinate is the larger one. Bit i of `port_blocked` belongs to port code i, and bit 0 is ignored.
- R10: Starting in phase 0 and following the returned ports and phases hop by hop, any source reaches any destination and then gets the local port. Along the way the phase never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Routing request present this cycle |
| cur_x | input | CW | X coordinate of this router |
| cur_y | input | CW | Y coordinate of this router |
| cur_z | input | CW | Z coordinate of this router |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| dst_z | input | CW | Destination Z coordinate |
| phase_in | input | 2 | Phase carried by the head flit: 0 X-Y plane, 1 Y-Z plane, 2 escape |
| port_blocked | input | 7 | Per-output-port blocked or congested flag, indexed by port code |
| out_valid | output | 1 | Registered result valid |
| out_port | output | 3 | Chosen output port code |
| out_esc_vc | output | 1 | 1 when the escape virtual-channel class is used |
| phase_out | output | 2 | Updated phase for the head flit |

## Verification
The bench aims at the plane boundary. With X just resolved, a design that held the packet in phase 0, or one that let it leave before X was zero, would report the wrong phase or send it in Z too early. It blocks every productive port to make sure the fallback goes to the dimension-order port and not to some free but unproductive one. It also sets all blocked flags while in escape, where a faulty design would stall or go back to adaptive routing. Random hop-by-hop walks with random blocking catch any route that re-enters a plane, leaves escape, or fails to arrive.

// File: rtl/pa_route_pkg.sv
`timescale 1ns/1ps
package pa_route_pkg;

    localparam int NDIM  = 3;
    localparam int NPORT = 1 + 2 * NDIM;
    localparam int PW    = $clog2(NPORT);

    typedef enum logic [1:0] {
        PH_XY  = 2'd0,
        PH_YZ  = 2'd1,
        PH_ESC = 2'd2,
        PH_RSV = 2'd3
    } phase_e;

    typedef struct packed {
        logic [PW-1:0] port;
        logic          esc_vc;
        phase_e        phase;
    } route_t;

    // Port code of the plus-going port of a dimension; minus is one above.
    function automatic logic [PW-1:0] plus_port(input int dim);
        return PW'(1 + 2 * dim);
    endfunction

    // Lowest dimension that belongs to the plane of a given phase.
    function automatic int plane_base(input phase_e ph);
        return (ph == PH_XY) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pa_axis_dir.sv
`timescale 1ns/1ps
module pa_axis_dir
    import pa_route_pkg::*;
#(
    parameter int CW  = 4,
    parameter int DIM = 0
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] dst,
    output logic          need,
    output logic [PW-1:0] port
);
    localparam logic [PW-1:0] P_PLUS  = plus_port(DIM);
    localparam logic [PW-1:0] P_MINUS = P_PLUS + PW'(1);

    always_comb begin
        need = (cur != dst);
        if (!need)
            port = '0;
        else if (dst > cur)
            port = P_PLUS;
        else
            port = P_MINUS;
    end
endmodule

// File: rtl/pa_plane_pick.sv
`timescale 1ns/1ps
module pa_plane_pick
    import pa_route_pkg::*;
(
    input  phase_e                   phase_in,
    input  logic [NDIM-1:0]          need,
    input  logic [NDIM-1:0][PW-1:0]  dport,
    input  logic [NPORT-1:0]         blocked,
    output route_t                   route
);
    logic [(1<<PW)-1:0] blk_w;
    phase_e             ph_norm;
    phase_e             eff;
    logic               arrived;
    logic               found;
    logic [PW-1:0]      pick;
    logic [PW-1:0]      dor_port;
    int                 base;

    assign blk_w = {{((1<<PW)-NPORT){1'b0}}, blocked};

    always_comb begin
        arrived = ~|need;
        ph_norm = (phase_in == PH_RSV) ? PH_ESC : phase_in;

        // Plane advance and illegal-plane fallback
        eff = ph_norm;
        if (eff == PH_XY && !need[0])
            eff = PH_YZ;
        else if (eff == PH_YZ && need[0])
            eff = PH_ESC;

        // Dimension-order port: first unresolved of X, Y, Z
        dor_port = dport[NDIM-1];
        for (int d = NDIM - 2; d >= 0; d--)
            if (need[d]) dor_port = dport[d];

        // Adaptive choice: lowest free productive dimension of the plane
        base  = plane_base(eff);
        found = 1'b0;
        pick  = '0;
        for (int d = 0; d < NDIM; d++) begin
            if (!found && d >= base && d <= base + 1 &&
                need[d] && !blk_w[dport[d]]) begin
                found = 1'b1;
                pick  = dport[d];
            end
        end

        if (arrived) begin
            route.port   = '0;
            route.esc_vc = (ph_norm == PH_ESC);
            route.phase  = ph_norm;
        end else if (eff != PH_ESC && found) begin
            route.port   = pick;
            route.esc_vc = 1'b0;
            route.phase  = eff;
        end else begin
            route.port   = dor_port;
            route.esc_vc = 1'b1;
            route.phase  = PH_ESC;
        end
    end
endmodule

// File: rtl/pa_route_sel.sv
`timescale 1ns/1ps
module pa_route_sel
    import pa_route_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] cur_z,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] dst_z,
    input  logic [1:0]    phase_in,
    input  logic [6:0]    port_blocked,
    output logic          out_valid,
    output logic [2:0]    out_port,
    output logic          out_esc_vc,
    output logic [1:0]    phase_out
);
    logic [NDIM-1:0][CW-1:0] cur_v;
    logic [NDIM-1:0][CW-1:0] dst_v;
    logic [NDIM-1:0]         need;
    logic [NDIM-1:0][PW-1:0] dport;
    route_t                  nxt;
    route_t                  r_q;

    assign cur_v = {cur_z, cur_y, cur_x};
    assign dst_v = {dst_z, dst_y, dst_x};

    for (genvar g = 0; g < NDIM; g++) begin : g_axis
        pa_axis_dir #(.CW(CW), .DIM(g)) u_dir (
            .cur  (cur_v[g]),
            .dst  (dst_v[g]),
            .need (need[g]),
            .port (dport[g])
        );
    end

    pa_plane_pick u_pick (
        .phase_in (phase_e'(phase_in)),
        .need     (need),
        .dport    (dport),
        .blocked  (port_blocked),
        .route    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            r_q       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) r_q <= nxt;
        end
    end

    assign out_port   = r_q.port;
    assign out_esc_vc = r_q.esc_vc;
    assign phase_out  = r_q.phase;

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (rst)
        in_valid && cur_x == dst_x && cur_y == dst_y && cur_z == dst_z
        |=> out_port == 3'd0); // R2
    AST_X_BEFORE_LEAVE: assert property (@(posedge clk) disable iff (rst)
        in_valid && phase_in == 2'd0 && cur_x != dst_x |=> phase_out != 2'd1); // R3
    AST_NO_PLANE_BACK: assert property (@(posedge clk) disable iff (rst)
        in_valid && phase_in == 2'd1 |=> phase_out != 2'd0); // R5
    AST_ADAPT_FREE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_esc_vc && out_port != 3'd0
        |-> ((($past({1'b0, port_blocked})) >> out_port) & 8'd1) == 8'd0); // R6
    AST_ESC_STICKY: assert property (@(posedge clk) disable iff (rst)
        in_valid && phase_in[1] |=> phase_out == 2'd2 && out_esc_vc); // R7
endmodule

// File: tb/pa_route_sel_bench.sv
`timescale 1ns/1ps
module pa_route_sel_bench;
    localparam int CW   = 4;
    localparam int SPAN = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, cur_z = '0;
    logic [CW-1:0] dst_x = '0, dst_y = '0, dst_z = '0;
    logic [1:0]    phase_in = '0;
    logic [6:0]    port_blocked = '0;
    logic          out_valid;
    logic [2:0]    out_port;
    logic          out_esc_vc;
    logic [1:0]    phase_out;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int    port;
        int    esc;
        int    phase;
        string tag;
        int    cyc;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pa_route_sel #(.CW(CW)) u_pa_route_sel (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .phase_in(phase_in), .port_blocked(port_blocked),
        .out_valid(out_valid), .out_port(out_port),
        .out_esc_vc(out_esc_vc), .phase_out(phase_out)
    );

    // Reference written from the requirements
    function automatic exp_t model(int cx, int cy, int cz, int dx, int dy, int dz,
                                   int ph, logic [6:0] blk);
        exp_t e;
        int off[3];
        int want[3];
        int mode;
        off[0] = dx - cx; off[1] = dy - cy; off[2] = dz - cz;
        for (int d = 0; d < 3; d++)
            want[d] = (off[d] > 0) ? 1 + 2*d : ((off[d] < 0) ? 2 + 2*d : 0);
        e.tag = ""; e.cyc = 0;
        if (off[0] == 0 && off[1] == 0 && off[2] == 0) begin
            e.port = 0; e.phase = (ph == 3) ? 2 : ph; e.esc = (e.phase == 2) ? 1 : 0;
            return e;
        end
        mode = (ph == 3) ? 2 : ph;
        if (mode == 0 && off[0] == 0) mode = 1;
        else if (mode == 1 && off[0] != 0) mode = 2;
        if (mode < 2) begin
            for (int d = mode; d <= mode + 1; d++)
                if (want[d] != 0 && !blk[want[d]]) begin
                    e.port = want[d]; e.esc = 0; e.phase = mode;
                    return e;
                end
        end
        e.esc = 1; e.phase = 2; e.port = 0;
        for (int d = 2; d >= 0; d--) if (want[d] != 0) e.port = want[d];
        return e;
    endfunction

    task automatic chk(bit ok, string tag, string what, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    task automatic send(int cx, int cy, int cz, int dx, int dy, int dz,
                        int ph, logic [6:0] blk, string tag);
        exp_t e;
        @(posedge clk); #2;
        cur_x = CW'(cx); cur_y = CW'(cy); cur_z = CW'(cz);
        dst_x = CW'(dx); dst_y = CW'(dy); dst_z = CW'(dz);
        phase_in = 2'(ph); port_blocked = blk; in_valid = 1'b1;
        e = model(cx, cy, cz, dx, dy, dz, ph, blk);
        e.tag = tag; e.cyc = cyc;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #2;
        in_valid = 1'b0;
        port_blocked = 7'h7f;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() != 0 && exp_q[0].cyc == cyc - 1) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(out_valid == 1'b1, "R1", "out_valid", int'(out_valid), 1);
                chk(int'(out_port) == e.port && int'(out_esc_vc) == e.esc &&
                    int'(phase_out) == e.phase, e.tag, "port*8+esc*4+phase",
                    int'(out_port)*8 + int'(out_esc_vc)*4 + int'(phase_out),
                    e.port*8 + e.esc*4 + e.phase);
            end else if (out_valid) begin
                chk(1'b0, "R1", "unexpected out_valid", 1, 0);
            end
        end
    end

    task automatic walk(int nw, int heavy);
        for (int w = 0; w < nw; w++) begin
            int c[3];
            int d[3];
            int ph;
            int prev;
            bit arrived;
            logic [6:0] blk;
            for (int k = 0; k < 3; k++) begin
                c[k] = $urandom_range(SPAN - 1);
                d[k] = $urandom_range(SPAN - 1);
            end
            ph = 0; arrived = 0;
            for (int h = 0; h < 60 && !arrived; h++) begin
                blk = heavy ? 7'($urandom) | 7'($urandom) : 7'($urandom) & 7'($urandom);
                send(c[0], c[1], c[2], d[0], d[1], d[2], ph, blk, "R10");
                idle();
                @(negedge clk); #1;
                prev = ph;
                ph = int'(phase_out);
                chk(!(prev == 1 && ph == 0) && !(prev == 2 && ph != 2), "R5",
                    "phase step old*4+new", prev*4 + ph, prev*4 + ((ph < prev) ? prev : ph));
                case (int'(out_port))
                    0: arrived = 1;
                    1: c[0]++; 2: c[0]--;
                    3: c[1]++; 4: c[1]--;
                    5: c[2]++; 6: c[2]--;
                    default: ;
                endcase
            end
            chk(arrived && c[0] == d[0] && c[1] == d[1] && c[2] == d[2], "R10",
                "arrived", int'(arrived), 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // Arrival in each phase
        send(3, 4, 5, 3, 4, 5, 0, 7'h7f, "R2");
        send(3, 4, 5, 3, 4, 5, 1, 7'h00, "R2");
        send(3, 4, 5, 3, 4, 5, 2, 7'h00, "R2");
        send(3, 4, 5, 3, 4, 5, 3, 7'h00, "R2");
        // X-Y plane adaptive choices and priority
        send(2, 2, 2, 6, 7, 9, 0, 7'h00, "R4");
        send(2, 2, 2, 6, 7, 9, 0, 7'h02, "R3");
        send(9, 9, 2, 1, 1, 9, 0, 7'h10, "R3");
        send(9, 9, 2, 1, 1, 9, 0, 7'h7c, "R9");
        // Plane advance
        send(5, 8, 1, 5, 3, 6, 0, 7'h00, "R5");
        send(5, 8, 1, 5, 3, 6, 0, 7'h10, "R5");
        send(5, 8, 9, 5, 8, 3, 0, 7'h00, "R5");
        send(5, 8, 1, 5, 3, 6, 1, 7'h00, "R5");
        // All adaptive choices blocked
        send(2, 2, 2, 6, 7, 9, 0, 7'h0a, "R6");
        send(5, 8, 1, 5, 3, 6, 1, 7'h30, "R6");
        send(5, 8, 1, 5, 3, 6, 0, 7'h7e, "R6");
        // Escape mode ignores blocks, dimension order
        send(9, 2, 2, 1, 7, 9, 2, 7'h7f, "R7");
        send(4, 2, 2, 4, 7, 9, 2, 7'h00, "R7");
        send(4, 7, 9, 4, 7, 3, 3, 7'h7f, "R7");
        // Phase Y-Z with X unresolved
        send(1, 2, 2, 6, 7, 9, 1, 7'h00, "R8");
        send(12, 2, 2, 6, 2, 2, 1, 7'h00, "R8");
        idle();
        // Random streaming burst
        for (int i = 0; i < 300; i++)
            send($urandom_range(SPAN-1), $urandom_range(SPAN-1), $urandom_range(SPAN-1),
                 $urandom_range(SPAN-1), $urandom_range(SPAN-1), $urandom_range(SPAN-1),
                 $urandom_range(3), 7'($urandom), "R9");
        idle();
        repeat (3) @(posedge clk);
        walk(40, 0);
        walk(20, 1);
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R1", "pending results", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1: watchdog expired got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule